// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block supplies the address for a synchronous burst memory that serves up to four beats per access. A full address is captured whenever either of two active-low start strobes is seen low at a rising clock edge while the block is enabled. After that, each enabled edge with the active-low step input low moves the burst to its next beat. Only the two low address bits change during a burst. The upper bits keep the value they had at capture.

The beat order is picked when the address is captured. A low level on the order-select input gives wrap-around counting (start, start+1, ... modulo four). A high level gives XOR ordering, in which beat n carries the start bits XOR n. The high level is the default. Bursts are optional: a strobe on every cycle captures a fresh address each cycle with no dead cycle. A strobe always overrides a step that arrives in the same cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `addr_out` is all zeros and `beat_idx` is 0.
- R2: When `en` is high and `start_a_n` or `start_b_n` (or both) is low at a rising edge, after that edge `addr_out` equals the captured `addr_in` and `beat_idx` is 0.
- R3: A strobe in the same cycle as a low `step_n` acts as a plain capture: the step is discarded and `beat_idx` becomes 0.
- R4: When `en` is high, both strobes are high and `step_n` is low, `beat_idx` increases by one modulo 4 and `addr_out[ADDR_W-1:2]` stays unchanged.
- R5: When `en` is high and both strobes and `step_n` are high, `addr_out` and `beat_idx` hold their values.
- R6: If `order_n` was 0 at capture, the low two bits of `addr_out` equal (start bits + `beat_idx`) mod 4.
- R7: If `order_n` was 1 at capture, the low two bits of `addr_out` equal start bits XOR `beat_idx`.
- R8: `order_n` is sampled only at capture. A change of `order_n` during a burst does not alter the sequence.
- R9: While `en` is low, the strobes, `step_n` and `addr_in` have no effect, and both outputs hold.
- R10: Steps after the fourth beat keep wrapping within the same four-address block. The fifth address equals the first.
- R11: Captures on consecutive cycles each take effect, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable. When low, all commands are ignored |
| start_a_n | input | 1 | First capture strobe, active low |
| start_b_n | input | 1 | Second capture strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| order_n | input | 1 | Beat order: 0 = wrap-around count, 1 = XOR order |
| addr_in | input | ADDR_W | Address captured on a strobe |
| addr_out | output | ADDR_W | Current burst address |
| beat_idx | output | 2 | Beat number within the burst |

## Verification
Every piece of state is visible at the ports in the cycle after it is written. A bad capture shows up as a wrong `addr_out` on the first beat. A bad beat counter or a bad latched order shows up as a wrong low pair of bits, or a wrong `beat_idx`, one edge after the offending step. The latched order is checked by changing `order_n` in the middle of a burst: if the order were read live rather than latched, the next beat would come out wrong. Steps past the fourth beat expose any carry out of the two-bit field, because the carry would corrupt the upper bits.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Burst length is four beats, so the beat field is two bits.
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } seq_cmd_e;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_seq_pkg::*;
(
    input  logic     en,
    input  logic     start_a_n,
    input  logic     start_b_n,
    input  logic     step_n,
    output seq_cmd_e cmd
);

    logic any_start;

    assign any_start = ~start_a_n | ~start_b_n;

    // A capture strobe wins over a step in the same cycle.
    always_comb begin
        if (!en) begin
            cmd = CMD_HOLD;
        end else if (any_start) begin
            cmd = CMD_LOAD;
        end else if (!step_n) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

endmodule

// File: rtl/burst_beat_order.sv
module burst_beat_order #(
    parameter int BW = 2
) (
    input  logic [BW-1:0] start_bits,
    input  logic [BW-1:0] beat,
    input  logic          xor_mode,
    output logic [BW-1:0] low_bits
);

    logic [BW-1:0] lin_bits;
    logic [BW-1:0] xor_bits;

    // Modulo 2**BW wrap comes from the truncated sum.
    assign lin_bits = BW'(start_bits + beat);

    // Bitwise XOR ordering, one gate per bit.
    for (genvar i = 0; i < BW; i++) begin : g_xor
        assign xor_bits[i] = start_bits[i] ^ beat[i];
    end

    assign low_bits = xor_mode ? xor_bits : lin_bits;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start_a_n,
    input  logic              start_b_n,
    input  logic              step_n,
    input  logic              order_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BEAT_W-1:0] beat_idx
);

    localparam int UP_W = ADDR_W - BEAT_W;
    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    typedef struct packed {
        logic [UP_W-1:0]   upper;
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
        logic              xor_mode;
    } seq_state_t;

    seq_state_t    s_d, s_q;
    seq_cmd_e      cmd;
    logic [BEAT_W-1:0] low_bits;

    burst_cmd_decode u_dec (
        .en        (en),
        .start_a_n (start_a_n),
        .start_b_n (start_b_n),
        .step_n    (step_n),
        .cmd       (cmd)
    );

    always_comb begin
        s_d = s_q;
        unique case (cmd)
            CMD_LOAD: begin
                s_d.upper    = addr_in[ADDR_W-1:BEAT_W];
                s_d.start    = addr_in[BEAT_W-1:0];
                s_d.beat     = '0;
                s_d.xor_mode = order_n;
            end
            CMD_STEP: begin
                s_d.beat = BEAT_W'(s_q.beat + BEAT_ONE);
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    burst_beat_order #(.BW(BEAT_W)) u_order (
        .start_bits (s_q.start),
        .beat       (s_q.beat),
        .xor_mode   (s_q.xor_mode),
        .low_bits   (low_bits)
    );

    assign addr_out = {s_q.upper, low_bits};
    assign beat_idx = s_q.beat;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              start_a_n,
    input logic              start_b_n,
    input logic              step_n,
    input logic              order_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        beat_idx
);

    logic load_c, step_c, idle_c;
    logic lin_q;

    assign load_c = en && (!start_a_n || !start_b_n);
    assign step_c = en && start_a_n && start_b_n && !step_n;
    assign idle_c = en && start_a_n && start_b_n && step_n;

    // Order chosen at the last capture, tracked from the ports.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lin_q <= 1'b0;
        end else if (load_c) begin
            lin_q <= !order_n;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |-> (addr_out == '0 && beat_idx == 2'd0));

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_c |=> (addr_out == $past(addr_in) && beat_idx == 2'd0));

    assert_step_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_c |=> (beat_idx == 2'($past(beat_idx) + 2'd1)
                    && addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idle_c |=> ($stable(addr_out) && $stable(beat_idx)));

    assert_linear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_c && lin_q) |=> addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1));

    assert_xor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_c && !lin_q) |=> (addr_out[1:0] ^ $past(addr_out[1:0]))
                               == ($past(beat_idx) ^ 2'($past(beat_idx) + 2'd1)));

    assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(addr_out) && $stable(beat_idx)));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .start_a_n (start_a_n),
    .start_b_n (start_b_n),
    .step_n    (step_n),
    .order_n   (order_n),
    .addr_in   (addr_in),
    .addr_out  (addr_out),
    .beat_idx  (beat_idx)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en, sa_n, sb_n, st_n, ord_n;
    logic [AW-1:0] a_in;
    logic [AW-1:0] a_out;
    logic [1:0]    b_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .start_a_n (sa_n),
        .start_b_n (sb_n),
        .step_n    (st_n),
        .order_n   (ord_n),
        .addr_in   (a_in),
        .addr_out  (a_out),
        .beat_idx  (b_idx)
    );

    typedef struct packed {
        logic          en;
        logic          sa_n;
        logic          sb_n;
        logic          st_n;
        logic          ord_n;
        logic [AW-1:0] addr;
        logic [AW-1:0] exp_addr;
        logic [1:0]    exp_beat;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b1,1'b1,1'b0,20'h12341,20'h12341,2'd0,4'd2},  // R2 capture via A, linear
        '{1'b1,1'b1,1'b1,1'b0,1'b0,20'h00000,20'h12342,2'd1,4'd6},  // R6
        '{1'b1,1'b1,1'b1,1'b0,1'b0,20'h00000,20'h12343,2'd2,4'd6},  // R6
        '{1'b1,1'b1,1'b1,1'b0,1'b0,20'h00000,20'h12340,2'd3,4'd6},  // R6 wrap 3->0
        '{1'b1,1'b1,1'b1,1'b0,1'b0,20'h00000,20'h12341,2'd0,4'd10}, // R10 fifth beat
        '{1'b1,1'b1,1'b1,1'b1,1'b0,20'hFFFFF,20'h12341,2'd0,4'd5},  // R5 hold
        '{1'b1,1'b1,1'b0,1'b1,1'b1,20'hABCD1,20'hABCD1,2'd0,4'd2},  // R2 capture via B, xor
        '{1'b1,1'b1,1'b1,1'b0,1'b0,20'h00000,20'hABCD0,2'd1,4'd8},  // R8 order pin flipped
        '{1'b1,1'b1,1'b1,1'b0,1'b0,20'h00000,20'hABCD3,2'd2,4'd7},  // R7
        '{1'b1,1'b1,1'b1,1'b0,1'b0,20'h00000,20'hABCD2,2'd3,4'd7},  // R7
        '{1'b1,1'b1,1'b1,1'b0,1'b1,20'h00000,20'hABCD1,2'd0,4'd10}, // R10
        '{1'b0,1'b0,1'b0,1'b0,1'b0,20'h00000,20'hABCD1,2'd0,4'd9},  // R9 disabled
        '{1'b1,1'b0,1'b1,1'b0,1'b0,20'h55552,20'h55552,2'd0,4'd3},  // R3 strobe beats step
        '{1'b1,1'b0,1'b1,1'b1,1'b0,20'h0F0F3,20'h0F0F3,2'd0,4'd11}, // R11
        '{1'b1,1'b1,1'b0,1'b1,1'b1,20'h70002,20'h70002,2'd0,4'd11}, // R11
        '{1'b1,1'b1,1'b1,1'b0,1'b0,20'h00000,20'h70003,2'd1,4'd4},  // R4 2^1
        '{1'b1,1'b0,1'b0,1'b1,1'b0,20'h00003,20'h00003,2'd0,4'd2},  // R2 both strobes
        '{1'b1,1'b1,1'b1,1'b0,1'b0,20'h00000,20'h00000,2'd1,4'd4}   // R4 upper unchanged
    };

    task automatic check(input int req, input logic [AW-1:0] ea, input logic [1:0] eb);
        n_chk++;
        if (a_out !== ea || b_idx !== eb) begin
            n_fail++;
            $display("FAIL R%0d: addr=%h beat=%0d expected addr=%h beat=%0d",
                     req, a_out, b_idx, ea, eb);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        en = v.en; sa_n = v.sa_n; sb_n = v.sb_n; st_n = v.st_n;
        ord_n = v.ord_n; a_in = v.addr;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0; sa_n = 1'b1; sb_n = 1'b1; st_n = 1'b1;
        ord_n = 1'b1; a_in = '0;
        repeat (3) @(posedge clk);
        #1;
        check(1, '0, 2'd0);  // R1 reset state
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check(int'(VECS[i].req), VECS[i].exp_addr, VECS[i].exp_beat);
        end

        // R10: eight steps from an interleaved start of 2 return to the start
        drive('{1'b1,1'b0,1'b1,1'b1,1'b1,20'h3C4E2,20'h3C4E2,2'd0,4'd2});
        for (int k = 0; k < 8; k++) begin
            drive('{1'b1,1'b1,1'b1,1'b0,1'b1,20'h0,20'h0,2'd0,4'd10});
        end
        check(10, 20'h3C4E2, 2'd0);

        // R1: reset in the middle of a burst clears both outputs
        drive('{1'b1,1'b1,1'b1,1'b0,1'b1,20'h0,20'h0,2'd0,4'd4});
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(1, '0, 2'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        finish_run();
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            finish_run();
        end
    end

endmodule